// File: doc/BRIEF.md
# Rotating-Slot Shared Memory Arbiter

This block shares one internal memory among eight requesters through a fixed rotating slot. A pointer steps one position per clock in strict circular order, and the requester it points at owns that cycle's memory window. Each requester has a valid line, a class bit, an access description and a four-long write bus. It holds valid until it sees its one-cycle grant. Every completed access is answered by a done pulse on the following cycle. For reads the returned data appear on a shared bus alongside that pulse.

A normal request is served only in the requester's own slot. Its wait is therefore set by the distance from the current slot to the requester's index, whatever the other requesters do. An opportunistic request may also take whichever slot is coming up when that slot's owner has nothing pending. This gives more throughput, but the wait now depends on traffic. Accesses are a single 32-bit long, a burst of up to four consecutive longs in one window, or a 16-bit half of a long. The storage is a plain register file that is reset to zero.

Top module: `rr_slot_arb`

## Requirements
- R1: While rst_ni is low, slot_o is 0 and gnt_o, done_o and rdata_o are all zero. After release, the first slot is owner 0.
- R2: slot_o advances by one every clock and wraps from N_REQ-1 to 0.
- R3: A normal request (req_opp_i low) is granted only in the cycle where slot_o equals the requester's index. For a requester with index i posted while the slot is s, the grant comes (i - s) mod N_REQ cycles later.
- R4: An opportunistic request (req_opp_i high) is granted in the current slot when the slot's owner has no valid request.
- R5: The owner of the current slot, if valid, is always granted, whatever its class and whatever borrowers are waiting.
- R6: When several opportunistic requesters compete for an idle slot, the first one found stepping forward from the owner in circular order wins.
- R7: gnt_o has at most one bit set. done_o equals the previous cycle's gnt_o.
- R8: A long access (req_word_i low) with length field L covers longs base..base+L, where base is address bits [7:2]. Write data lane k is taken from wdata bits [32k+31:32k]. Read data lane k is returned in rdata_o bits [32k+31:32k]. Lanes past L read as zero.
- R9: A word write replaces bits [31:16] of the addressed long when address bit 1 is 1, and bits [15:0] when it is 0, using wdata bits [15:0]. The other half is kept. The length field is ignored.
- R10: A word read returns the half chosen by address bit 1 in rdata_o[15:0]. All other rdata_o bits are zero.
- R11: Burst long indices wrap modulo the memory depth (64 longs), so a burst starting at index 62 continues at 0.
- R12: On the done pulse of a write, rdata_o is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | N_REQ | Request pending, one bit per requester |
| req_opp_i | input | N_REQ | 1 = opportunistic class, 0 = normal |
| req_we_i | input | N_REQ | 1 = write, 0 = read |
| req_word_i | input | N_REQ | 1 = 16-bit word access, 0 = long access |
| req_len_i | input | N_REQ*2 | Extra longs in the burst (0..3), per requester |
| req_addr_i | input | N_REQ*8 | Byte address, per requester |
| req_wdata_i | input | N_REQ*128 | Four write lanes, per requester |
| gnt_o | output | N_REQ | One-cycle grant |
| done_o | output | N_REQ | Completion pulse, one cycle after grant |
| rdata_o | output | 128 | Read lanes, valid with done_o |
| slot_o | output | 3 | Current slot owner |

## Verification
One requester posted at a known slot position separates the fixed-latency normal path from any early grant. An idle owner with a single opportunistic requester exposes the borrowing path. Mixed traffic, with an owner and a borrower posted together, tells owner priority apart from first-come ordering. Three borrowers spread round the ring show whether the nearest-after-owner rule holds as the slot moves. Bursts that start near the top of the memory, word writes over known longs, and reads of both halves check lane placement, wrapping and half preservation against a behavioural model that is compared on every clock.

// File: rtl/arb_pkg.sv
package arb_pkg;
  parameter int unsigned LONG_W    = 32;
  parameter int unsigned HALF_W    = 16;
  parameter int unsigned MAX_BURST = 4;
  parameter int unsigned LEN_W     = $clog2(MAX_BURST);
  parameter int unsigned ADDR_W    = 8;
  parameter int unsigned BUS_W     = LONG_W * MAX_BURST;
  parameter int unsigned IDX_MEM_W = ADDR_W - 2;
  parameter int unsigned DEPTH     = 2 ** IDX_MEM_W;

  typedef struct packed {
    logic               we;
    logic               word;
    logic [LEN_W-1:0]   len;
    logic [ADDR_W-1:0]  addr;
  } acc_t;
endpackage

// File: rtl/rr_slot_ring.sv
module rr_slot_ring #(
  parameter int unsigned N_REQ = 8,
  localparam int unsigned IDX_W = $clog2(N_REQ)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [IDX_W-1:0] slot_o
);
  logic [IDX_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           cnt_q <= '0;
    else if (cnt_q == IDX_W'(N_REQ - 1))   cnt_q <= '0;
    else                                   cnt_q <= cnt_q + 1'b1;
  end

  assign slot_o = cnt_q;
endmodule

// File: rtl/rr_slot_pick.sv
module rr_slot_pick #(
  parameter int unsigned N_REQ = 8,
  localparam int unsigned IDX_W = $clog2(N_REQ)
) (
  input  logic [IDX_W-1:0] slot_i,
  input  logic [N_REQ-1:0] valid_i,
  input  logic [N_REQ-1:0] opp_i,
  output logic [N_REQ-1:0] gnt_o,
  output logic [IDX_W-1:0] sel_o
);
  logic [N_REQ-1:0] gnt_d;
  logic [IDX_W-1:0] sel_d;

  // owner first, then borrowers in circular order after the owner
  always_comb begin
    logic             found;
    logic [IDX_W:0]   sum;
    logic [IDX_W-1:0] j;
    gnt_d = '0;
    sel_d = slot_i;
    found = 1'b0;
    sum   = '0;
    j     = '0;
    if (valid_i[slot_i]) begin
      gnt_d[slot_i] = 1'b1;
      found         = 1'b1;
    end
    for (int k = 1; k < N_REQ; k++) begin
      sum = {1'b0, slot_i} + (IDX_W+1)'(k);
      if (sum >= (IDX_W+1)'(N_REQ)) sum = sum - (IDX_W+1)'(N_REQ);
      j = sum[IDX_W-1:0];
      if (!found && valid_i[j] && opp_i[j]) begin
        gnt_d[j] = 1'b1;
        sel_d    = j;
        found    = 1'b1;
      end
    end
  end

  assign gnt_o = gnt_d;
  assign sel_o = sel_d;
endmodule

// File: rtl/rr_slot_mem.sv
module rr_slot_mem
  import arb_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  acc_t             acc_i,
  input  logic [BUS_W-1:0] wdata_i,
  output logic [BUS_W-1:0] rdata_o
);
  logic [LONG_W-1:0]    mem_q [DEPTH];
  logic [BUS_W-1:0]     rdata_q;
  logic [BUS_W-1:0]     rd_d;
  logic [IDX_MEM_W-1:0] lane_idx [MAX_BURST];
  logic [MAX_BURST-1:0] lane_on;
  logic [LONG_W-1:0]    wr_long [MAX_BURST];

  logic [IDX_MEM_W-1:0] base;
  logic                 hi_half;
  assign base    = acc_i.addr[ADDR_W-1:2];
  assign hi_half = acc_i.addr[1];

  for (genvar b = 0; b < MAX_BURST; b++) begin : g_lane
    logic [LONG_W-1:0] cur;
    assign lane_idx[b] = base + IDX_MEM_W'(b);
    assign cur         = mem_q[lane_idx[b]];
    if (b == 0) begin : g_first
      assign lane_on[b] = 1'b1;
      always_comb begin
        if (!acc_i.word)   wr_long[b] = wdata_i[LONG_W-1:0];
        else if (hi_half)  wr_long[b] = {wdata_i[HALF_W-1:0], cur[HALF_W-1:0]};
        else               wr_long[b] = {cur[LONG_W-1:HALF_W], wdata_i[HALF_W-1:0]};
      end
      always_comb begin
        if (acc_i.we)        rd_d[LONG_W-1:0] = '0;
        else if (!acc_i.word) rd_d[LONG_W-1:0] = cur;
        else if (hi_half)    rd_d[LONG_W-1:0] = {{HALF_W{1'b0}}, cur[LONG_W-1:HALF_W]};
        else                 rd_d[LONG_W-1:0] = {{HALF_W{1'b0}}, cur[HALF_W-1:0]};
      end
    end else begin : g_rest
      assign lane_on[b] = !acc_i.word && (LEN_W'(b) <= acc_i.len);
      assign wr_long[b] = wdata_i[b*LONG_W +: LONG_W];
      assign rd_d[b*LONG_W +: LONG_W] = (lane_on[b] && !acc_i.we) ? cur : '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int a = 0; a < DEPTH; a++) mem_q[a] <= '0;
      rdata_q <= '0;
    end else begin
      rdata_q <= en_i ? rd_d : '0;
      if (en_i && acc_i.we) begin
        for (int b = 0; b < MAX_BURST; b++)
          if (lane_on[b]) mem_q[lane_idx[b]] <= wr_long[b];
      end
    end
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/rr_slot_arb.sv
module rr_slot_arb
  import arb_pkg::*;
#(
  parameter int unsigned N_REQ = 8,
  localparam int unsigned IDX_W = $clog2(N_REQ)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [N_REQ-1:0]       req_valid_i,
  input  logic [N_REQ-1:0]       req_opp_i,
  input  logic [N_REQ-1:0]       req_we_i,
  input  logic [N_REQ-1:0]       req_word_i,
  input  logic [N_REQ*LEN_W-1:0] req_len_i,
  input  logic [N_REQ*ADDR_W-1:0] req_addr_i,
  input  logic [N_REQ*BUS_W-1:0] req_wdata_i,
  output logic [N_REQ-1:0]       gnt_o,
  output logic [N_REQ-1:0]       done_o,
  output logic [BUS_W-1:0]       rdata_o,
  output logic [IDX_W-1:0]       slot_o
);
  logic [IDX_W-1:0] slot;
  logic [IDX_W-1:0] sel;
  logic [N_REQ-1:0] gnt;
  logic [N_REQ-1:0] done_q;
  acc_t             acc;
  logic [BUS_W-1:0] wdata;

  rr_slot_ring #(.N_REQ(N_REQ)) u_ring (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .slot_o (slot)
  );

  rr_slot_pick #(.N_REQ(N_REQ)) u_pick (
    .slot_i  (slot),
    .valid_i (req_valid_i),
    .opp_i   (req_opp_i),
    .gnt_o   (gnt),
    .sel_o   (sel)
  );

  always_comb begin
    acc.we   = req_we_i[sel];
    acc.word = req_word_i[sel];
    acc.len  = req_len_i[sel*LEN_W +: LEN_W];
    acc.addr = req_addr_i[sel*ADDR_W +: ADDR_W];
    wdata    = req_wdata_i[sel*BUS_W +: BUS_W];
  end

  rr_slot_mem u_mem (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (|gnt),
    .acc_i   (acc),
    .wdata_i (wdata),
    .rdata_o (rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) done_q <= '0;
    else         done_q <= gnt;
  end

  assign gnt_o  = gnt;
  assign done_o = done_q;
  assign slot_o = slot;
endmodule

// File: rtl/rr_slot_arb_chk.sv
module rr_slot_arb_chk #(
  parameter int unsigned N_REQ = 8,
  localparam int unsigned IDX_W = $clog2(N_REQ)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [IDX_W-1:0] slot_o,
  input logic [N_REQ-1:0] req_valid_i,
  input logic [N_REQ-1:0] req_opp_i,
  input logic [N_REQ-1:0] gnt_o,
  input logic [N_REQ-1:0] done_o
);
  assert_slot_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> slot_o == (($past(slot_o) == IDX_W'(N_REQ - 1)) ? '0 : $past(slot_o) + 1'b1));

  for (genvar i = 0; i < N_REQ; i++) begin : g_own
    assert_normal_own_slot_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (gnt_o[i] && !req_opp_i[i]) |-> slot_o == IDX_W'(i));
  end

  assert_borrow_served_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(req_valid_i & req_opp_i)) |-> (|gnt_o));

  assert_owner_first_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i[slot_o] |-> gnt_o[slot_o]);

  assert_gnt_onehot_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));

  assert_done_follows_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> done_o == $past(gnt_o));

  assert_gnt_needs_valid_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o & ~req_valid_i) == '0);
endmodule

bind rr_slot_arb rr_slot_arb_chk #(.N_REQ(N_REQ)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .slot_o      (slot_o),
  .req_valid_i (req_valid_i),
  .req_opp_i   (req_opp_i),
  .gnt_o       (gnt_o),
  .done_o      (done_o)
);

// File: tb/rr_slot_arb_tb.sv
module rr_slot_arb_tb;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #10 clk = ~clk;

  logic [N-1:0]     vld = '0, opp = '0, we = '0, wrd = '0;
  logic [N*2-1:0]   len = '0;
  logic [N*8-1:0]   addr = '0;
  logic [N*128-1:0] wdat = '0;
  logic [N-1:0]     gnt_o, done_o;
  logic [127:0]     rdata_o;
  logic [2:0]       slot_o;

  rr_slot_arb #(.N_REQ(N)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(vld), .req_opp_i(opp),
    .req_we_i(we), .req_word_i(wrd), .req_len_i(len), .req_addr_i(addr),
    .req_wdata_i(wdat), .gnt_o(gnt_o), .done_o(done_o), .rdata_o(rdata_o),
    .slot_o(slot_o));

  int errors = 0, checks = 0, cyc = 0;
  int mslot = 0;
  logic [31:0]  mmem [64];
  logic [N-1:0] eg = '0, exp_done = '0;
  logic [127:0] exp_rd = '0;
  logic [127:0] got_rd [N];
  int gcyc [N];
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic logic [N-1:0] model_grant();
    logic [N-1:0] g = '0;
    if (vld[mslot]) g[mslot] = 1'b1;
    else for (int k = 1; k < N; k++) begin
      int j = (mslot + k) % N;
      if (g == 0 && vld[j] && opp[j]) g[j] = 1'b1;
    end
    return g;
  endfunction

  task automatic model_update();
    exp_done = eg;
    exp_rd   = '0;
    for (int g = 0; g < N; g++) if (eg[g]) begin
      logic [7:0] a = addr[g*8 +: 8];
      int n = wrd[g] ? 1 : int'(len[g*2 +: 2]) + 1;
      for (int b = 0; b < n; b++) begin
        int idx = (int'(a[7:2]) + b) % 64;
        logic [31:0] cur = mmem[idx];
        if (we[g]) begin
          if (!wrd[g]) mmem[idx] = wdat[g*128 + b*32 +: 32];
          else if (a[1]) mmem[idx][31:16] = wdat[g*128 +: 16];
          else mmem[idx][15:0] = wdat[g*128 +: 16];
        end else begin
          if (!wrd[g]) exp_rd[b*32 +: 32] = cur;
          else exp_rd[31:0] = a[1] ? {16'h0, cur[31:16]} : {16'h0, cur[15:0]};
        end
      end
    end
    mslot = (mslot + 1) % N;
  endtask

  // one clock: compare before the edge, advance model at the edge, retire at negedge
  task automatic cycle();
    #5;
    eg = model_grant();
    chk(gnt_o === eg, "R3 R4 R5 R6 grant", 128'(gnt_o), 128'(eg));
    chk(slot_o === 3'(mslot), "R2 slot", 128'(slot_o), 128'(mslot));
    chk(done_o === exp_done, "R7 done", 128'(done_o), 128'(exp_done));
    if (exp_done != 0) begin
      chk(rdata_o === exp_rd, "R8 R10 R11 R12 rdata", rdata_o, exp_rd);
      for (int i = 0; i < N; i++) if (exp_done[i]) got_rd[i] = rdata_o;
    end
    for (int i = 0; i < N; i++) if (gnt_o[i]) gcyc[i] = cyc;
    @(posedge clk);
    model_update();
    @(negedge clk);
    vld = vld & ~eg;
    cyc++;
  endtask

  task automatic run(input int n);
    for (int k = 0; k < n; k++) cycle();
  endtask

  task automatic wait_slot(input int s);
    while (mslot != s) cycle();
  endtask

  task automatic post(input int i, input bit o, input bit w, input bit h, input logic [1:0] l,
                      input logic [7:0] a, input logic [127:0] d);
    vld[i] = 1'b1; opp[i] = o; we[i] = w; wrd[i] = h;
    len[i*2 +: 2] = l; addr[i*8 +: 8] = a; wdat[i*128 +: 128] = d;
    gcyc[i] = -1;
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int t0;
    for (int a = 0; a < 64; a++) mmem[a] = '0;
    for (int i = 0; i < N; i++) begin got_rd[i] = '0; gcyc[i] = -1; end
    #5;
    // R1 reset state
    chk(slot_o === 3'd0, "R1 slot reset", 128'(slot_o), 0);
    chk(gnt_o === '0, "R1 gnt reset", 128'(gnt_o), 0);
    chk(done_o === '0, "R1 done reset", 128'(done_o), 0);
    chk(rdata_o === '0, "R1 rdata reset", rdata_o, 0);
    @(negedge clk); @(negedge clk);
    rst_ni = 1'b1;
    run(3);

    // R8 R11 long burst write wrapping past the top, then read back
    post(3, 0, 1, 0, 2'd3, 8'hF8, 128'h44444444_33333333_22222222_11111111);
    run(10);
    post(5, 0, 0, 0, 2'd3, 8'hF8, '0);
    run(10);
    chk(got_rd[5] === 128'h44444444_33333333_22222222_11111111, "R11 burst wrap read",
        got_rd[5], 128'h44444444_33333333_22222222_11111111);

    // R9 R10 R12 word access
    post(1, 0, 1, 0, 2'd0, 8'h04, 128'h11223344);
    run(10);
    chk(got_rd[1] === '0, "R12 write done rdata", got_rd[1], 0);
    post(1, 0, 1, 1, 2'd3, 8'h06, {96'hFFFF, 32'h0000BEEF});
    run(10);
    post(2, 0, 0, 0, 2'd0, 8'h04, '0);
    run(10);
    chk(got_rd[2] === 128'hBEEF3344, "R9 upper half write", got_rd[2], 128'hBEEF3344);
    post(2, 0, 0, 1, 2'd2, 8'h04, '0);
    run(10);
    chk(got_rd[2] === 128'h3344, "R10 low half read", got_rd[2], 128'h3344);
    post(2, 0, 0, 1, 2'd0, 8'h06, '0);
    run(10);
    chk(got_rd[2] === 128'hBEEF, "R10 high half read", got_rd[2], 128'hBEEF);

    // R8 R9 word write ignores length, then 3-lane read leaves lane 3 zero
    post(0, 0, 1, 1, 2'd3, 8'h08, 128'h55555555_66666666_77777777_1234AAAA);
    run(10);
    post(0, 0, 0, 0, 2'd2, 8'h08, '0);
    run(10);
    chk(got_rd[0] === 128'h0000AAAA, "R8 short burst lanes", got_rd[0], 128'h0000AAAA);

    // R3 fixed latency
    wait_slot(6);
    t0 = cyc;
    post(4, 0, 0, 0, 2'd0, 8'h00, '0);
    run(10);
    chk(gcyc[4] - t0 == 6, "R3 normal latency", 128'(gcyc[4] - t0), 6);

    // R4 borrow idle slot
    wait_slot(0);
    t0 = cyc;
    post(6, 1, 0, 0, 2'd0, 8'h00, '0);
    run(4);
    chk(gcyc[6] == t0, "R4 borrow now", 128'(gcyc[6] - t0), 0);

    // R5 owner ahead of borrower
    wait_slot(2);
    t0 = cyc;
    post(2, 0, 0, 0, 2'd0, 8'h00, '0);
    post(3, 1, 0, 0, 2'd0, 8'h04, '0);
    run(4);
    chk(gcyc[2] == t0, "R5 owner wins", 128'(gcyc[2] - t0), 0);
    chk(gcyc[3] == t0 + 1, "R5 borrower next", 128'(gcyc[3] - t0), 1);

    // R6 nearest after owner
    wait_slot(1);
    t0 = cyc;
    post(5, 1, 0, 0, 2'd0, 8'h00, '0);
    post(7, 1, 0, 0, 2'd0, 8'h00, '0);
    post(3, 1, 0, 0, 2'd0, 8'h00, '0);
    run(5);
    chk(gcyc[3] == t0, "R6 first borrower", 128'(gcyc[3] - t0), 0);
    chk(gcyc[5] == t0 + 1, "R6 second borrower", 128'(gcyc[5] - t0), 1);
    chk(gcyc[7] == t0 + 2, "R6 third borrower", 128'(gcyc[7] - t0), 2);

    // all eight at once, mixed classes
    for (int i = 0; i < N; i++) post(i, i[0], 0, 0, 2'(i), 8'(i * 8), '0);
    run(12);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule